// File: doc/BRIEF.md
# Flow-Control Credit NOP Generator

This block returns receive-buffer space to the far end of a packetized point-to-point link. Six receive buffers are tracked: command and data for posted requests, command and data for non-posted requests, and command and data for responses. Each time the local receiver frees a slot in one of them, it pulses a release line. The block keeps a pending count per buffer and raises a request for a transmit slot while any count is nonzero. When the link scheduler grants a slot, the block builds a 4-byte NOP information packet. Each 2-bit field in that packet hands back up to three slots of one buffer. Whatever does not fit in the field stays pending for a later NOP.

The same block also holds the matching credit tracker for the transmit direction. Every NOP dword received from the partner is decoded, and its six 2-bit fields are added to per-buffer available-credit counters. These counters stop at a configured ceiling. A sticky overflow flag records any return that would have gone past the ceiling. The disconnect flag, the isochronous and diagnostic bits and the 8-bit acknowledge value are taken from inputs and placed into the packet unchanged.

Top module: `fc_credit_nop`

## Requirements
- R1: An emitted NOP dword has bits 5:0 (command, 000000b = NOP), bit 7 and bits 23:22 at 0. Bit 20 equals `isoc_flag`, bit 21 equals `diag_flag` and bits 31:24 equal `ack_seq`, all sampled in the grant cycle.
- R2: Returned counts sit at fixed bit positions. Posted command is at 9:8, posted data at 11:10, response command at 13:12, response data at 15:14, non-posted command at 17:16 and non-posted data at 19:18. Release bit i of `rel_pulse` belongs to buffer i, in the order posted cmd, posted data, non-posted cmd, non-posted data, response cmd, response data.
- R3: `nop_valid` is high for exactly the cycle after a cycle with `nop_grant` high. `nop_dword` holds the packet built from the state in that grant cycle.
- R4: Each field reports min(pending, 3) for its buffer. On a grant, the reported amount is subtracted from that buffer's pending count.
- R5: A release in the same cycle as a grant is added after the subtraction, so no release is lost.
- R6: `nop_req` is high exactly when at least one pending count is nonzero. It reflects a release from the previous cycle.
- R7: Bit 6 of the NOP (disconnect) equals `link_stop` sampled in the grant cycle.
- R8: When `rx_valid` is high and `rx_dword[5:0]` is 000000b, each returned field is added to its buffer's `avail_cnt` slice on the next edge. Slice i is CW bits wide, starting at bit i*CW.
- R9: A received dword with a nonzero command field leaves every `avail_cnt` slice and `credit_ovf` unchanged.
- R10: An available count never exceeds CRED_MAX. A return that would exceed it clamps the count to CRED_MAX and sets that buffer's `credit_ovf` bit, which stays set until reset.
- R11: After reset, all pending counts, `nop_req`, `nop_valid`, `nop_dword`, `avail_cnt` and `credit_ovf` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rel_pulse | input | 6 | One-cycle release pulse per receive buffer |
| nop_grant | input | 1 | Transmit slot granted for a NOP this cycle |
| link_stop | input | 1 | Link-stop sequence starting; sets the disconnect bit |
| isoc_flag | input | 1 | Isochronous bit copied into the NOP |
| diag_flag | input | 1 | Diagnostic bit copied into the NOP |
| ack_seq | input | 8 | Receive next-packet-to-acknowledge value |
| nop_req | output | 1 | Credits are pending; a NOP slot is wanted |
| nop_valid | output | 1 | `nop_dword` holds a fresh packet |
| nop_dword | output | 32 | Assembled NOP packet |
| rx_valid | input | 1 | A received control dword is present |
| rx_dword | input | 32 | Received control dword |
| avail_cnt | output | 6*CW | Available transmit credits per buffer |
| credit_ovf | output | 6 | Sticky per-buffer credit overflow flags |

## Verification
The checker assumes that `nop_grant` is a single-cycle strobe and that the packet registered after it reflects only that cycle's inputs. It also assumes that a release is never more than one pulse per buffer per clock. The stimulus drives every input once per cycle on the falling edge, and a release is one bit per buffer, so both assumptions always hold. Received dwords come from a mix of the block's own NOPs and random words with random command fields. This exercises both the accepted path and the ignored path, and pushes the trackers into saturation.

// File: rtl/fcn_pkg.sv
package fcn_pkg;
  localparam int NBUF = 6;
  localparam logic [5:0] CMD_NOP = 6'b000000;

  typedef enum logic [2:0] {
    BUF_PCMD = 3'd0, BUF_PDAT = 3'd1, BUF_NCMD = 3'd2,
    BUF_NDAT = 3'd3, BUF_RCMD = 3'd4, BUF_RDAT = 3'd5
  } buf_e;

  // Bit position of each buffer's 2-bit return field inside the NOP dword
  function automatic int field_lsb(input int idx);
    case (idx)
      BUF_PCMD: return 8;
      BUF_PDAT: return 10;
      BUF_NCMD: return 16;
      BUF_NDAT: return 18;
      BUF_RCMD: return 12;
      default:  return 14;
    endcase
  endfunction
endpackage

// File: rtl/fcn_pend_ctr.sv
module fcn_pend_ctr #(
  parameter int PEND_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rel,
  input  logic       take,
  output logic       pend_nz,
  output logic [1:0] rpt
);
  localparam logic [PEND_W-1:0] PMAX = '1;

  logic [PEND_W-1:0] cnt;
  logic [PEND_W-1:0] after_take;

  always_comb begin
    rpt        = (cnt > PEND_W'(3)) ? 2'd3 : cnt[1:0];
    after_take = take ? (cnt - PEND_W'(rpt)) : cnt;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (rel && after_take != PMAX)
      cnt <= after_take + PEND_W'(1);
    else
      cnt <= after_take;
  end

  assign pend_nz = |cnt;
endmodule

// File: rtl/fcn_credit_acc.sv
module fcn_credit_acc #(
  parameter int CRED_MAX = 20,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          add_en,
  input  logic [1:0]    add,
  output logic [CW-1:0] cnt,
  output logic          ovf
);
  logic [CW:0] sum;

  assign sum = {1'b0, cnt} + (CW+1)'(add);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (add_en) begin
      if (sum > (CW+1)'(CRED_MAX)) begin
        cnt <= CW'(CRED_MAX);
        ovf <= 1'b1;
      end else begin
        cnt <= sum[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/fc_credit_nop.sv
module fc_credit_nop import fcn_pkg::*; #(
  parameter  int PEND_W   = 5,
  parameter  int CRED_MAX = 20,
  localparam int CW       = $clog2(CRED_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NBUF-1:0]    rel_pulse,
  input  logic               nop_grant,
  input  logic               link_stop,
  input  logic               isoc_flag,
  input  logic               diag_flag,
  input  logic [7:0]         ack_seq,
  output logic               nop_req,
  output logic               nop_valid,
  output logic [31:0]        nop_dword,
  input  logic               rx_valid,
  input  logic [31:0]        rx_dword,
  output logic [NBUF*CW-1:0] avail_cnt,
  output logic [NBUF-1:0]    credit_ovf
);
  logic [NBUF-1:0] pend_nz;
  logic [1:0]      rpt [NBUF];
  logic            rx_is_nop;
  logic [31:0]     nop_next;

  assign rx_is_nop = rx_valid && (rx_dword[5:0] == CMD_NOP);

  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    localparam int LSB = field_lsb(i);

    fcn_pend_ctr #(.PEND_W(PEND_W)) u_pend (
      .clk     (clk),
      .rst     (rst),
      .rel     (rel_pulse[i]),
      .take    (nop_grant),
      .pend_nz (pend_nz[i]),
      .rpt     (rpt[i])
    );

    fcn_credit_acc #(.CRED_MAX(CRED_MAX), .CW(CW)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .add_en (rx_is_nop),
      .add    (rx_dword[LSB +: 2]),
      .cnt    (avail_cnt[i*CW +: CW]),
      .ovf    (credit_ovf[i])
    );
  end

  assign nop_req = |pend_nz;

  always_comb begin
    nop_next        = '0;
    nop_next[5:0]   = CMD_NOP;
    nop_next[6]     = link_stop;
    nop_next[20]    = isoc_flag;
    nop_next[21]    = diag_flag;
    nop_next[31:24] = ack_seq;
    for (int i = 0; i < NBUF; i++)
      nop_next[field_lsb(i) +: 2] = rpt[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nop_valid <= 1'b0;
      nop_dword <= '0;
    end else begin
      nop_valid <= nop_grant;
      if (nop_grant)
        nop_dword <= nop_next;
    end
  end
endmodule

// File: rtl/fcn_chk.sv
module fcn_chk #(
  parameter int NB       = 6,
  parameter int CW       = 5,
  parameter int CRED_MAX = 20
) (
  input logic             clk,
  input logic             rst,
  input logic [NB-1:0]    rel_pulse,
  input logic             nop_grant,
  input logic             link_stop,
  input logic             nop_req,
  input logic             nop_valid,
  input logic [31:0]      nop_dword,
  input logic [NB*CW-1:0] avail_cnt,
  input logic [NB-1:0]    credit_ovf
);
  AST_VALID_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst) nop_grant |=> nop_valid); // R3
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) !nop_grant |=> !nop_valid); // R3
  AST_FIXED_ZEROS: assert property (@(posedge clk) disable iff (rst)
    nop_valid |-> (nop_dword[5:0] == 6'd0 && !nop_dword[7] && nop_dword[23:22] == 2'd0)); // R1
  AST_DISC_SRC: assert property (@(posedge clk) disable iff (rst)
    nop_valid |-> nop_dword[6] == $past(link_stop)); // R7
  AST_IDLE_STAYS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (!nop_req && rel_pulse == '0) |=> !nop_req); // R6
  AST_REL_RAISES_REQ: assert property (@(posedge clk) disable iff (rst)
    (|rel_pulse) |=> nop_req); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (credit_ovf != '0) |=> ((credit_ovf & $past(credit_ovf)) == $past(credit_ovf))); // R10

  for (genvar i = 0; i < NB; i++) begin : g_bound
    AST_CRED_BOUND: assert property (@(posedge clk) disable iff (rst)
      avail_cnt[i*CW +: CW] <= CW'(CRED_MAX)); // R10
  end
endmodule

bind fc_credit_nop fcn_chk #(.NB(fcn_pkg::NBUF), .CW(CW), .CRED_MAX(CRED_MAX)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rel_pulse  (rel_pulse),
  .nop_grant  (nop_grant),
  .link_stop  (link_stop),
  .nop_req    (nop_req),
  .nop_valid  (nop_valid),
  .nop_dword  (nop_dword),
  .avail_cnt  (avail_cnt),
  .credit_ovf (credit_ovf)
);

// File: tb/fc_credit_nop_bench.sv
module fc_credit_nop_bench;
  localparam int NB = 6;
  localparam int PEND_W = 5;
  localparam int PMAXV = 31;
  localparam int CRED_MAX = 20;
  localparam int CW = $clog2(CRED_MAX + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NB-1:0] rel_pulse = '0;
  logic nop_grant = 1'b0, link_stop = 1'b0, isoc_flag = 1'b0, diag_flag = 1'b0;
  logic [7:0] ack_seq = '0;
  logic nop_req, nop_valid;
  logic [31:0] nop_dword;
  logic rx_valid = 1'b0;
  logic [31:0] rx_dword = '0;
  logic [NB*CW-1:0] avail_cnt;
  logic [NB-1:0] credit_ovf;

  fc_credit_nop #(.PEND_W(PEND_W), .CRED_MAX(CRED_MAX)) u_fc_credit_nop (
    .clk(clk), .rst(rst), .rel_pulse(rel_pulse), .nop_grant(nop_grant),
    .link_stop(link_stop), .isoc_flag(isoc_flag), .diag_flag(diag_flag),
    .ack_seq(ack_seq), .nop_req(nop_req), .nop_valid(nop_valid),
    .nop_dword(nop_dword), .rx_valid(rx_valid), .rx_dword(rx_dword),
    .avail_cnt(avail_cnt), .credit_ovf(credit_ovf)
  );

  always #10 clk = ~clk;

  int pm [NB];
  int cm [NB];
  bit om [NB];
  int checks = 0;
  int fails = 0;
  logic [31:0] last_exp = '0;

  function automatic int lsb_of(input int i);
    case (i)
      0: return 8;   1: return 10;  2: return 16;
      3: return 18;  4: return 12;  default: return 14;
    endcase
  endfunction

  function automatic int min3(input int v);
    return (v > 3) ? 3 : v;
  endfunction

  function automatic logic [31:0] build_nop(input bit ls, input bit iso, input bit dg,
                                            input logic [7:0] ack);
    logic [31:0] d = '0;
    d[6] = ls; d[20] = iso; d[21] = dg; d[31:24] = ack;
    for (int i = 0; i < NB; i++) d[lsb_of(i) +: 2] = 2'(min3(pm[i]));
    return d;
  endfunction

  function automatic bit any_pending();
    for (int i = 0; i < NB; i++) if (pm[i] != 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin pm[i] = 0; cm[i] = 0; om[i] = 1'b0; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rel_pulse = '0; nop_grant = 1'b0; rx_valid = 1'b0; link_stop = 1'b0;
    model_reset();
    @(posedge clk); @(posedge clk); #1;
    chk(nop_valid == 1'b0 && nop_dword == '0 && nop_req == 1'b0, "R11 outputs",
        {nop_valid, nop_req, 30'd0}, 32'd0);
    chk(avail_cnt == '0 && credit_ovf == '0, "R11 credits", 32'(avail_cnt), 32'd0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic cycle(input logic [NB-1:0] rel, input bit g, input bit ls,
                       input bit iso, input bit dg, input logic [7:0] ack,
                       input bit rv, input logic [31:0] rd, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    rel_pulse = rel; nop_grant = g; link_stop = ls; isoc_flag = iso;
    diag_flag = dg; ack_seq = ack; rx_valid = rv; rx_dword = rd;
    exp = build_nop(ls, iso, dg, ack);
    for (int i = 0; i < NB; i++) begin
      int r = g ? min3(pm[i]) : 0;
      pm[i] = pm[i] - r;
      if (rel[i] && pm[i] != PMAXV) pm[i]++;
    end
    if (rv && rd[5:0] == 6'd0) begin
      for (int i = 0; i < NB; i++) begin
        int f = int'(rd[lsb_of(i) +: 2]);
        if (cm[i] + f > CRED_MAX) begin cm[i] = CRED_MAX; om[i] = 1'b1; end
        else cm[i] = cm[i] + f;
      end
    end
    @(posedge clk); #1;
    chk(nop_valid == g, {"R3 valid ", tag}, 32'(nop_valid), 32'(g));
    if (g) begin
      chk(nop_dword == exp, {"R1 R2 R4 R5 R7 dword ", tag}, nop_dword, exp);
      last_exp = exp;
    end
    chk(nop_req == any_pending(), {"R6 req ", tag}, 32'(nop_req), 32'(any_pending()));
    for (int i = 0; i < NB; i++) begin
      chk(avail_cnt[i*CW +: CW] == CW'(cm[i]), {"R8 R9 R10 avail ", tag},
          32'(avail_cnt[i*CW +: CW]), 32'(cm[i]));
      chk(credit_ovf[i] == om[i], {"R10 ovf ", tag}, 32'(credit_ovf[i]), 32'(om[i]));
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    model_reset();
    do_reset();
    // R4: five posted-command releases drain as 3 then 2
    for (int k = 0; k < 5; k++) cycle(6'b000001, 0, 0, 0, 0, 8'h00, 0, 0, "R4 fill");
    cycle(6'b0, 1, 0, 0, 0, 8'h5A, 0, 0, "R4 first three");
    cycle(6'b0, 1, 0, 1, 1, 8'hA5, 0, 0, "R4 remainder two R1 flags");
    cycle(6'b0, 0, 0, 0, 0, 8'h00, 0, 0, "R6 empty");
    // R2: one release in each buffer, reported in its own field
    cycle(6'b111111, 0, 0, 0, 0, 8'h00, 0, 0, "R2 fill");
    cycle(6'b000000, 1, 0, 0, 0, 8'h11, 0, 0, "R2 fields");
    // R5: release during grant is kept
    for (int k = 0; k < 3; k++) cycle(6'b100000, 0, 0, 0, 0, 8'h00, 0, 0, "R5 fill");
    cycle(6'b100000, 1, 0, 0, 0, 8'h22, 0, 0, "R5 same cycle");
    cycle(6'b000000, 1, 1, 0, 0, 8'h33, 0, 0, "R7 disconnect R5 leftover");
    // R9: non-NOP command ignored
    cycle(6'b0, 0, 0, 0, 0, 8'h00, 1, 32'h00FF_FF01, "R9 non-nop");
    // R8 then R10: repeated full returns saturate
    for (int k = 0; k < 8; k++)
      cycle(6'b0, 0, 0, 0, 0, 8'h00, 1, 32'h000F_FF00, "R8 R10 fill");
    cycle(6'b0, 0, 0, 0, 0, 8'h00, 1, 32'h000F_FF3F, "R9 after saturation");
    do_reset();
    for (int k = 0; k < 3000; k++) begin
      logic [NB-1:0] rel = NB'($urandom) & NB'($urandom);
      bit g = ($urandom % 3) == 0;
      bit rv = ($urandom % 6) == 0;
      logic [31:0] rd = (($urandom % 4) == 0) ? $urandom : (last_exp & 32'h000F_FF00);
      cycle(rel, g, ($urandom % 16) == 0, 1'($urandom), 1'($urandom), 8'($urandom),
            rv, rd, "random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule